// File: doc/BRIEF.md
# Supply Monitor Reset Generator

This block turns digital comparator results into a primary reset and two supplementary status outputs. The primary reset is asserted while the main supply sits below its trip point. It is also asserted while an active-high manual reset pin is high. When the supply comes back, the reset is held for a timeout whose length is picked at run time by a two-bit selection field. The supplementary outputs report, without any timeout, whether each auxiliary supply is at or above its own trip point.

Every comparator flag and the manual reset pin first pass through a two-flop synchroniser. Every output is registered. A change at an input pin therefore reaches the outputs three clock edges later. The one exception is the release of the primary reset after the supply recovers, which also waits out the timeout. A supply dip during the timeout clears the count, so the timeout starts again from zero. The four timeout lengths are parameters and must each be at least one.

Top module: `supmon_reset`

## Requirements
- R1: While `rst_n` is low, `rst_out_o` is 1 and `mon_ok_o` is all zeros, whatever the other inputs are.
- R2: When `cmp_main_i` goes to 0 (supply below trip), `rst_out_o` is 1 from the third clock edge after the change onward, for as long as `cmp_main_i` stays 0.
- R3: When `cmp_main_i` goes to 1 and stays there, with `man_rst_i` low, `rst_out_o` is still 1 after L+2 clock edges and is 0 after L+3 edges. L is `TMO_SEL0`, `TMO_SEL1`, `TMO_SEL2` or `TMO_SEL3` for `tsel_i` values 0, 1, 2 and 3.
- R4: A low pulse on `cmp_main_i` of one clock period or longer, occurring during the timeout, restarts it. Release then comes L+3 edges after `cmp_main_i` returns to 1.
- R5: A high level on `man_rst_i` drives `rst_out_o` to 1 from the third clock edge after the rise onward.
- R6: When `man_rst_i` falls while the supply is good and the timeout has already expired, `rst_out_o` returns to 0 on the third edge after the fall, with no further timeout.
- R7: The manual reset does not start, stop or clear the timeout. If `man_rst_i` falls before the timeout ends, release follows the timeout as in R3.
- R8: `mon_ok_o[i]` equals `cmp_aux_i[i]` with a latency of exactly three clock edges (1 = auxiliary supply at or above trip), independent of `cmp_main_i`, `man_rst_i` and `tsel_i`.
- R9: Once the timeout has expired and the reset is released, later changes of `tsel_i` have no effect on `rst_out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| cmp_main_i | input | 1 | Main supply comparator, 1 when at or above trip |
| man_rst_i | input | 1 | Manual reset, active high, rests low |
| cmp_aux_i | input | NAUX | Auxiliary supply comparators, 1 when at or above trip |
| tsel_i | input | 2 | Timeout length selection |
| rst_out_o | output | 1 | Primary reset, active high |
| mon_ok_o | output | NAUX | Auxiliary supply status, 1 when good |

## Verification
The bench builds the block with timeout lengths of 5, 9, 14 and 22 cycles. These are short enough to walk every selection code to its exact release edge, and distinct enough that a swapped or miscoded selection shows up as a release on the wrong cycle. The 22-cycle setting, reached after a release at 5 cycles, also shows that a later selection change cannot bring the reset back. The short lengths leave room to place a one-cycle supply dip in the middle of a running timeout and to overlap the manual reset with a pending timeout.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    // Timeout selection codes: the value on the selection pins picks the limit.
    typedef enum logic [1:0] {
        TSEL_0 = 2'd0,
        TSEL_1 = 2'd1,
        TSEL_2 = 2'd2,
        TSEL_3 = 2'd3
    } tsel_e;

    function automatic int unsigned pick_limit(
        input logic [1:0]  sel,
        input int unsigned l0,
        input int unsigned l1,
        input int unsigned l2,
        input int unsigned l3
    );
        unique case (tsel_e'(sel))
            TSEL_0:  return l0;
            TSEL_1:  return l1;
            TSEL_2:  return l2;
            default: return l3;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    // Reset value 0: supplies are taken as bad and manual reset as idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/supmon_timer.sv
module supmon_timer #(
    parameter int unsigned TMO_SEL0 = 1000,
    parameter int unsigned TMO_SEL1 = 5000,
    parameter int unsigned TMO_SEL2 = 20000,
    parameter int unsigned TMO_SEL3 = 80000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ok_i,
    input  logic [1:0] sel_i,
    output logic       done_o
);
    import supmon_pkg::*;

    localparam int unsigned MAXL = max4(TMO_SEL0, TMO_SEL1, TMO_SEL2, TMO_SEL3);
    localparam int          CW   = $clog2(MAXL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t          st_d, st_q;
    logic [CW-1:0] lim;

    assign lim = CW'(pick_limit(sel_i, TMO_SEL0, TMO_SEL1, TMO_SEL2, TMO_SEL3));

    always_comb begin
        st_d = st_q;
        if (!ok_i) begin
            // Any cycle of bad supply restarts the timeout from zero.
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt >= lim - CW'(1)) begin
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        // done is sticky while the supply stays good: selection changes are ignored.
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

endmodule

// File: rtl/supmon_reset.sv
module supmon_reset #(
    parameter int unsigned TMO_SEL0 = 1000,
    parameter int unsigned TMO_SEL1 = 5000,
    parameter int unsigned TMO_SEL2 = 20000,
    parameter int unsigned TMO_SEL3 = 80000,
    parameter int          NAUX     = 2,
    parameter int          SYNC_STG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_main_i,
    input  logic            man_rst_i,
    input  logic [NAUX-1:0] cmp_aux_i,
    input  logic [1:0]      tsel_i,
    output logic            rst_out_o,
    output logic [NAUX-1:0] mon_ok_o
);

    localparam int SW = NAUX + 2;

    typedef struct packed {
        logic            rst;
        logic [NAUX-1:0] mon;
    } out_t;

    logic [SW-1:0]   raw_in;
    logic [SW-1:0]   sync_in;
    logic            main_ok_s;
    logic            man_s;
    logic [NAUX-1:0] aux_s;
    logic            tmo_done;
    out_t            out_d, out_q;

    assign raw_in = {cmp_aux_i, man_rst_i, cmp_main_i};

    supmon_sync #(
        .WIDTH (SW),
        .STAGES(SYNC_STG)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    assign main_ok_s = sync_in[0];
    assign man_s     = sync_in[1];
    assign aux_s     = sync_in[SW-1:2];

    supmon_timer #(
        .TMO_SEL0(TMO_SEL0),
        .TMO_SEL1(TMO_SEL1),
        .TMO_SEL2(TMO_SEL2),
        .TMO_SEL3(TMO_SEL3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .ok_i  (main_ok_s),
        .sel_i (tsel_i),
        .done_o(tmo_done)
    );

    always_comb begin
        out_d     = out_q;
        // Manual reset bypasses the timer; supply loss wins at once.
        out_d.rst = !main_ok_s || !tmo_done || man_s;
        out_d.mon = aux_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.rst <= 1'b1;
            out_q.mon <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rst_out_o = out_q.rst;
    assign mon_ok_o  = out_q.mon;

endmodule

// File: rtl/supmon_reset_chk.sv
module supmon_reset_chk #(
    parameter int NAUX = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmp_main_i,
    input logic            man_rst_i,
    input logic [NAUX-1:0] cmp_aux_i,
    input logic            rst_out_o,
    input logic [NAUX-1:0] mon_ok_o
);

    // Edges seen since reset release, saturating at 3 (input-to-output latency).
    logic [1:0] settle_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= 2'd0;
        end else if (settle_q != 2'd3) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    assign warm = (settle_q == 2'd3);

    p_low_supply_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(cmp_main_i, 3)) |-> rst_out_o);

    p_manual_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(man_rst_i, 3)) |-> rst_out_o);

    p_release_needs_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $fell(rst_out_o)) |-> ($past(cmp_main_i, 3) && !$past(man_rst_i, 3)));

    p_aux_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (mon_ok_o == $past(cmp_aux_i, 3)));

endmodule

bind supmon_reset supmon_reset_chk #(.NAUX(NAUX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_main_i(cmp_main_i),
    .man_rst_i (man_rst_i),
    .cmp_aux_i (cmp_aux_i),
    .rst_out_o (rst_out_o),
    .mon_ok_o  (mon_ok_o)
);

// File: tb/supmon_reset_bench.sv
module supmon_reset_bench;

    localparam int unsigned L0 = 5;
    localparam int unsigned L1 = 9;
    localparam int unsigned L2 = 14;
    localparam int unsigned L3 = 22;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmp_main;
    logic       man_rst;
    logic [1:0] cmp_aux;
    logic [1:0] tsel;
    logic       rst_out;
    logic [1:0] mon_ok;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    supmon_reset #(
        .TMO_SEL0(L0),
        .TMO_SEL1(L1),
        .TMO_SEL2(L2),
        .TMO_SEL3(L3),
        .NAUX    (2)
    ) u_supmon_reset (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_main_i(cmp_main),
        .man_rst_i (man_rst),
        .cmp_aux_i (cmp_aux),
        .tsel_i    (tsel),
        .rst_out_o (rst_out),
        .mon_ok_o  (mon_ok)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic int unsigned lim_of(input logic [1:0] s);
        case (s)
            2'd0:    return L0;
            2'd1:    return L1;
            2'd2:    return L2;
            default: return L3;
        endcase
    endfunction

    task automatic t_reset;
        rst_n = 1'b0; cmp_main = 1'b1; man_rst = 1'b0; cmp_aux = 2'b11; tsel = 2'd0;
        tick(3);
        chk("R1", "rst_out in reset", {1'b0, rst_out}, 2'b01);
        chk("R1", "mon_ok in reset", mon_ok, 2'b00);
        rst_n = 1'b1;
    endtask

    task automatic t_timeout(input logic [1:0] s);
        int unsigned l;
        l = lim_of(s);
        cmp_main = 1'b0;
        tick(4);
        chk("R2", "held while supply low", {1'b0, rst_out}, 2'b01);
        tsel = s;
        cmp_main = 1'b1;
        tick(l + 2);
        chk("R3", $sformatf("still held sel=%0d", s), {1'b0, rst_out}, 2'b01);
        tick(1);
        chk("R3", $sformatf("released sel=%0d", s), {1'b0, rst_out}, 2'b00);
    endtask

    task automatic t_drop;
        cmp_main = 1'b0;
        tick(2);
        chk("R2", "before latency", {1'b0, rst_out}, 2'b00);
        tick(1);
        chk("R2", "asserted after 3 edges", {1'b0, rst_out}, 2'b01);
    endtask

    task automatic t_dip;
        tsel = 2'd1;
        cmp_main = 1'b0;
        tick(4);
        cmp_main = 1'b1;
        tick(4);
        cmp_main = 1'b0;
        tick(1);
        cmp_main = 1'b1;
        tick(L1 + 2);
        chk("R4", "restarted timeout still held", {1'b0, rst_out}, 2'b01);
        tick(1);
        chk("R4", "released after restart", {1'b0, rst_out}, 2'b00);
    endtask

    task automatic t_manual;
        man_rst = 1'b1;
        tick(2);
        chk("R5", "before latency", {1'b0, rst_out}, 2'b00);
        tick(1);
        chk("R5", "manual asserts", {1'b0, rst_out}, 2'b01);
        tick(5);
        chk("R5", "manual held", {1'b0, rst_out}, 2'b01);
        man_rst = 1'b0;
        tick(2);
        chk("R6", "before release latency", {1'b0, rst_out}, 2'b01);
        tick(1);
        chk("R6", "no timeout after manual", {1'b0, rst_out}, 2'b00);
    endtask

    task automatic t_manual_pending;
        tsel = 2'd2;
        cmp_main = 1'b0;
        tick(4);
        man_rst = 1'b1;
        cmp_main = 1'b1;
        tick(3);
        man_rst = 1'b0;
        tick(L2 - 1);
        chk("R7", "timer still governs", {1'b0, rst_out}, 2'b01);
        tick(1);
        chk("R7", "release at timeout", {1'b0, rst_out}, 2'b00);
    endtask

    task automatic t_aux;
        cmp_aux = 2'b00;
        tick(4);
        chk("R8", "aux low", mon_ok, 2'b00);
        cmp_aux = 2'b01;
        tick(2);
        chk("R8", "aux before latency", mon_ok, 2'b00);
        tick(1);
        chk("R8", "aux bit0", mon_ok, 2'b01);
        cmp_aux = 2'b10;
        tick(3);
        chk("R8", "aux bit1", mon_ok, 2'b10);
        chk("R8", "main untouched by aux", {1'b0, rst_out}, 2'b00);
        cmp_main = 1'b0;
        man_rst = 1'b1;
        cmp_aux = 2'b11;
        tick(3);
        chk("R8", "aux under main reset", mon_ok, 2'b11);
        man_rst = 1'b0;
        cmp_main = 1'b1;
        tick(lim_of(tsel) + 3);
        chk("R8", "main back after aux test", {1'b0, rst_out}, 2'b00);
    endtask

    task automatic t_tsel_after;
        tsel = 2'd0;
        cmp_main = 1'b0;
        tick(4);
        cmp_main = 1'b1;
        tick(L0 + 3);
        chk("R9", "released on short timeout", {1'b0, rst_out}, 2'b00);
        tsel = 2'd3;
        tick(L3 + 10);
        chk("R9", "selection change ignored", {1'b0, rst_out}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        for (int s = 0; s < 4; s++) t_timeout(2'(s));
        t_drop();
        t_dip();
        t_manual();
        t_manual_pending();
        t_aux();
        t_tsel_after();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule